// File: doc/BRIEF.md
# I2C SCL Count Calculator

This block turns bus timing targets into the three count values an I2C master needs: the SCL high count, the SCL low count and the SDA hold count, all in core clock cycles. A host pulses `start` along with a speed mode, the core clock given as a ratio (`clk_ticks` cycles every `clk_ns` nanoseconds), the measured rise and fall times, an optional data hold time and two spike-filter lengths. The block samples all of these on the start pulse and runs through six ceiling divisions on one shared serial divider. It then back-solves the high and low counts and pads them so the whole SCL period reaches the target rate.

The result comes with a one-cycle `done` pulse. The outputs hold their values until the next result. If the back-solved high or low count would be negative, `error` is raised and all three counts read zero. Every count is the integer ceiling of `clk_ticks * t / clk_ns`, where t is the time in ns. `clk_ns` must be non-zero.

Top module: `i2c_scl_calc`

## Requirements
- R1: Each time value t (rise, fall, minimum high, minimum low, hold) becomes ceil(clk_ticks*t/clk_ns) core cycles.
- R2: Mode encoding 0=standard (100 kHz, min high/low 4000/4700 ns), 1=fast (400 kHz, 600/1300 ns), 2=fast-plus (1 MHz, 260/500 ns), 3=high speed (3.4 MHz, 60/160 ns). The period count is ceil(clk_ticks*1e9/(clk_ns*rate_hz)).
- R3: Before padding, high = hi_cnt - fall_cnt - 7 - spk and low = lo_cnt - rise_cnt + fall_cnt - 1.
- R4: If either back-solved count is below zero, `error` is 1 and `scl_hcnt`, `scl_lcnt` and `hold_cnt` are all 0. A count of exactly zero is not an error.
- R5: Let total = high + low + 7 + spk + rise_cnt + 1. If total is below the period count, half the shortfall (rounded down) is added to each count, and whatever remains after that goes to the low count. The final total is therefore never below the period count.
- R6: A `hold_ns` of 0 selects a hold time of 300 ns.
- R7: The spike length is `spk_high` in mode 3 and `spk_fast` in every other mode.
- R8: Inputs are sampled only in the cycle a start is accepted. A `start` while a calculation is running is ignored and produces no result.
- R9: `done` is a one-cycle pulse. The outputs stay stable after it. A `start` in the same cycle as `done` is accepted.
- R10: After reset, `done`, `error` and all counts are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; inputs are sampled with it |
| mode | input | 2 | Speed mode (0 std, 1 fast, 2 fast-plus, 3 high) |
| clk_ticks | input | 16 | Core clock ticks per `clk_ns` |
| clk_ns | input | 16 | Nanoseconds for `clk_ticks` ticks |
| rise_ns | input | 16 | SCL rise time in ns |
| fall_ns | input | 16 | SCL fall time in ns |
| hold_ns | input | 16 | SDA hold time in ns, 0 for default |
| spk_fast | input | 8 | Spike length for modes 0 to 2 |
| spk_high | input | 8 | Spike length for mode 3 |
| done | output | 1 | One-cycle result-valid pulse |
| error | output | 1 | Negative count detected |
| scl_hcnt | output | 16 | SCL high count |
| scl_lcnt | output | 16 | SCL low count |
| hold_cnt | output | 16 | SDA hold count |

## Verification
Two events can fall in the same cycle: a result being reported on `done`, and a new `start` being accepted. The bench waits until it sees `done` high and raises `start` in that same cycle with fresh inputs. The scoreboard then needs two correct results in order, and `done` must return low in between. A second collision is a `start` that arrives while the divider is still running. Here the bench checks that no extra result appears and that the result produced matches the inputs sampled at the first start, even though the inputs are scrambled right after it.

// File: rtl/i2c_scl_calc_pkg.sv
package i2c_scl_calc_pkg;

  typedef enum logic [1:0] {
    SPD_STD   = 2'd0,
    SPD_FAST  = 2'd1,
    SPD_FPLUS = 2'd2,
    SPD_HIGH  = 2'd3
  } spd_e;

  typedef struct packed {
    logic [11:0] rate_ticks;  // bus cycles per rate_ns
    logic [19:0] rate_ns;
    logic [12:0] hi_ns;       // minimum SCL high time
    logic [12:0] lo_ns;       // minimum SCL low time
  } spd_info_t;

  localparam int unsigned DFLT_HOLD_NS = 300;
  localparam int unsigned HI_OVH       = 7;
  localparam int unsigned LO_OVH       = 1;
  localparam int unsigned NUM_OPS      = 6;

  // operation index order inside the sequencer
  localparam int unsigned OP_PER  = 0;
  localparam int unsigned OP_RISE = 1;
  localparam int unsigned OP_FALL = 2;
  localparam int unsigned OP_HI   = 3;
  localparam int unsigned OP_LO   = 4;
  localparam int unsigned OP_HOLD = 5;

  function automatic spd_info_t spd_info(input spd_e m);
    spd_info_t s;
    case (m)
      SPD_STD:   s = '{12'd100,  20'd1000000, 13'd4000, 13'd4700};
      SPD_FAST:  s = '{12'd400,  20'd1000000, 13'd600,  13'd1300};
      SPD_FPLUS: s = '{12'd1,    20'd1000,    13'd260,  13'd500};
      default:   s = '{12'd3400, 20'd1000000, 13'd60,   13'd160};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/i2c_scl_div.sv
module i2c_scl_div #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         valid,
  output logic [W-1:0] quo
);
  localparam int CNTW = $clog2(W + 1);

  logic [W:0]      rem_q;
  logic [W-1:0]    dvd_q;
  logic [W-1:0]    den_q;
  logic [CNTW-1:0] cnt_q;
  logic [W:0]      shifted;
  logic            fits;

  assign shifted = {rem_q[W-1:0], dvd_q[W-1]};
  assign fits    = shifted >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dvd_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        rem_q <= '0;
        dvd_q <= num;
        den_q <= den;
        cnt_q <= CNTW'(W);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? (shifted - {1'b0, den_q}) : shifted;
        dvd_q <= {dvd_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) valid <= 1'b1;
      end
    end
  end

  assign quo = dvd_q;

  // R1: a finished quotient leaves a remainder smaller than the divisor
  assert_rem_below_den_R1: assert property (@(posedge clk) disable iff (rst)
    valid |-> (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/i2c_scl_opsel.sv
module i2c_scl_opsel
  import i2c_scl_calc_pkg::*;
#(
  parameter int TW = 16,
  parameter int NW = 40
) (
  input  logic [2:0]    idx,
  input  spd_e          mode,
  input  logic [TW-1:0] clk_ticks,
  input  logic [TW-1:0] clk_ns,
  input  logic [TW-1:0] rise_ns,
  input  logic [TW-1:0] fall_ns,
  input  logic [TW-1:0] hold_ns,
  output logic [NW-1:0] num,
  output logic [NW-1:0] den
);
  spd_info_t     inf;
  logic [NW-1:0] t_ns;
  logic [NW-1:0] per_den;

  always_comb begin
    inf     = spd_info(mode);
    per_den = NW'(clk_ns) * NW'(inf.rate_ticks);
    case (int'(idx))
      OP_RISE: t_ns = NW'(rise_ns);
      OP_FALL: t_ns = NW'(fall_ns);
      OP_HI:   t_ns = NW'(inf.hi_ns);
      OP_LO:   t_ns = NW'(inf.lo_ns);
      OP_HOLD: t_ns = (hold_ns == '0) ? NW'(DFLT_HOLD_NS) : NW'(hold_ns);
      default: t_ns = NW'(inf.rate_ns);
    endcase
    // ceiling division through a pre-added (divisor - 1)
    if (int'(idx) == OP_PER) begin
      den = per_den;
      num = NW'(clk_ticks) * t_ns + per_den - 1'b1;
    end else begin
      den = NW'(clk_ns);
      num = NW'(clk_ticks) * t_ns + NW'(clk_ns) - 1'b1;
    end
  end

endmodule

// File: rtl/i2c_scl_solve.sv
module i2c_scl_solve
  import i2c_scl_calc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] per_cnt,
  input  logic [CW-1:0] rise_cnt,
  input  logic [CW-1:0] fall_cnt,
  input  logic [CW-1:0] hi_cnt,
  input  logic [CW-1:0] lo_cnt,
  input  logic [CW-1:0] spk,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] lcnt,
  output logic          neg
);
  localparam int XW = CW + 4;

  function automatic logic signed [XW-1:0] sx(input logic [CW-1:0] v);
    return signed'(XW'(v));
  endfunction

  logic signed [XW-1:0] h0, l0, tot, gap, half, h1, l1, tot1;

  always_comb begin
    h0   = sx(hi_cnt) - sx(fall_cnt) - XW'(HI_OVH) - sx(spk);
    l0   = sx(lo_cnt) - sx(rise_cnt) + sx(fall_cnt) - XW'(LO_OVH);
    neg  = h0[XW-1] | l0[XW-1];
    tot  = h0 + l0 + XW'(HI_OVH) + sx(spk) + sx(rise_cnt) + XW'(LO_OVH);
    h1   = h0;
    l1   = l0;
    gap  = '0;
    half = '0;
    tot1 = tot;
    if (tot < sx(per_cnt)) begin
      gap  = sx(per_cnt) - tot;
      half = gap >>> 1;
      h1   = h0 + half;
      l1   = l0 + half;
      tot1 = tot + half + half;
      l1   = l1 + (sx(per_cnt) - tot1);
    end
    hcnt = CW'(h1);
    lcnt = CW'(l1);
  end

endmodule

// File: rtl/i2c_scl_calc.sv
module i2c_scl_calc
  import i2c_scl_calc_pkg::*;
#(
  parameter int TW = 16,
  parameter int SW = 8,
  parameter int CW = 16,
  parameter int NW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [TW-1:0] clk_ticks,
  input  logic [TW-1:0] clk_ns,
  input  logic [TW-1:0] rise_ns,
  input  logic [TW-1:0] fall_ns,
  input  logic [TW-1:0] hold_ns,
  input  logic [SW-1:0] spk_fast,
  input  logic [SW-1:0] spk_high,
  output logic          done,
  output logic          error,
  output logic [CW-1:0] scl_hcnt,
  output logic [CW-1:0] scl_lcnt,
  output logic [CW-1:0] hold_cnt
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} st_e;

  st_e           st_q;
  logic [2:0]    idx_q;
  spd_e          mode_q;
  logic [TW-1:0] ticks_q, ns_q, rise_q, fall_q, hold_q;
  logic [CW-1:0] spk_q;
  logic [CW-1:0] res_q [NUM_OPS];

  logic [NW-1:0] d_num, d_den, d_quo;
  logic          d_go, d_valid;
  logic [CW-1:0] s_h, s_l;
  logic          s_neg;

  assign d_go = (st_q == ST_ISSUE);

  i2c_scl_opsel #(.TW(TW), .NW(NW)) i_opsel (
    .idx(idx_q), .mode(mode_q), .clk_ticks(ticks_q), .clk_ns(ns_q),
    .rise_ns(rise_q), .fall_ns(fall_q), .hold_ns(hold_q),
    .num(d_num), .den(d_den)
  );

  i2c_scl_div #(.W(NW)) i_div (
    .clk(clk), .rst(rst), .go(d_go), .num(d_num), .den(d_den),
    .valid(d_valid), .quo(d_quo)
  );

  i2c_scl_solve #(.CW(CW)) i_solve (
    .per_cnt(res_q[OP_PER]), .rise_cnt(res_q[OP_RISE]), .fall_cnt(res_q[OP_FALL]),
    .hi_cnt(res_q[OP_HI]), .lo_cnt(res_q[OP_LO]), .spk(spk_q),
    .hcnt(s_h), .lcnt(s_l), .neg(s_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      mode_q   <= SPD_STD;
      ticks_q  <= '0;
      ns_q     <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      hold_q   <= '0;
      spk_q    <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
      scl_hcnt <= '0;
      scl_lcnt <= '0;
      hold_cnt <= '0;
      for (int i = 0; i < NUM_OPS; i++) res_q[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          mode_q  <= spd_e'(mode);
          ticks_q <= clk_ticks;
          ns_q    <= clk_ns;
          rise_q  <= rise_ns;
          fall_q  <= fall_ns;
          hold_q  <= hold_ns;
          spk_q   <= CW'((spd_e'(mode) == SPD_HIGH) ? spk_high : spk_fast);
          idx_q   <= '0;
          st_q    <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (d_valid) begin
          res_q[idx_q] <= d_quo[CW-1:0];
          if (int'(idx_q) == NUM_OPS - 1) begin
            st_q <= ST_FIN;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_ISSUE;
          end
        end
        default: begin
          done     <= 1'b1;
          error    <= s_neg;
          scl_hcnt <= s_neg ? '0 : s_h;
          scl_lcnt <= s_neg ? '0 : s_l;
          hold_cnt <= s_neg ? '0 : res_q[OP_HOLD];
          st_q     <= ST_IDLE;
        end
      endcase
    end
  end

  assert_err_zero_R4: assert property (@(posedge clk) disable iff (rst)
    error |-> (scl_hcnt == '0 && scl_lcnt == '0 && hold_cnt == '0));

  assert_period_met_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> (32'(scl_hcnt) + 32'(scl_lcnt) + HI_OVH + 32'(spk_q)
                          + 32'(res_q[OP_RISE]) + LO_OVH >= 32'(res_q[OP_PER])));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE && start) |=> $stable(mode_q) && $stable(ticks_q));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done && $stable(scl_hcnt) && $stable(scl_lcnt));

endmodule

// File: tb/test_i2c_scl_calc.sv
module test_i2c_scl_calc;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        err;
    logic [15:0] h, l, hd;
  } exp_t;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0]  mode = '0;
  logic [15:0] clk_ticks = '0, clk_ns = 16'd1, rise_ns = '0, fall_ns = '0, hold_ns = '0;
  logic [7:0]  spk_fast = '0, spk_high = '0;
  logic        done, error;
  logic [15:0] scl_hcnt, scl_lcnt, hold_cnt;

  int   checks = 0, errors = 0, pushed = 0, seen = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_calc i_i2c_scl_calc (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .clk_ticks(clk_ticks),
    .clk_ns(clk_ns), .rise_ns(rise_ns), .fall_ns(fall_ns), .hold_ns(hold_ns),
    .spk_fast(spk_fast), .spk_high(spk_high), .done(done), .error(error),
    .scl_hcnt(scl_hcnt), .scl_lcnt(scl_lcnt), .hold_cnt(hold_cnt)
  );

  function automatic longint cdiv(longint a, longint b);
    return (a + b - 1) / b;
  endfunction

  function automatic exp_t model(int m, longint ct, longint cn, longint r, longint f,
                                 longint hd, longint sf, longint sh);
    exp_t e;
    longint rt, rn, hi, lo, per, rc, fc, hc, lc, sp, h, l, tot, d;
    case (m)
      0: begin rt = 100;  rn = 1000000; hi = 4000; lo = 4700; end
      1: begin rt = 400;  rn = 1000000; hi = 600;  lo = 1300; end
      2: begin rt = 1;    rn = 1000;    hi = 260;  lo = 500;  end
      default: begin rt = 3400; rn = 1000000; hi = 60; lo = 160; end
    endcase
    per = cdiv(ct * rn, cn * rt);
    rc = cdiv(ct * r, cn);
    fc = cdiv(ct * f, cn);
    hc = cdiv(ct * hi, cn);
    lc = cdiv(ct * lo, cn);
    sp = (m == 3) ? sh : sf;
    h = hc - fc - 7 - sp;
    l = lc - rc + fc - 1;
    e.err = (h < 0 || l < 0);
    tot = h + l + 7 + sp + rc + 1;
    if (tot < per) begin
      d = (per - tot) / 2;
      h += d; l += d;
      l += per - (tot + 2 * d);
    end
    e.h  = e.err ? 16'd0 : 16'(h);
    e.l  = e.err ? 16'd0 : 16'(l);
    e.hd = e.err ? 16'd0 : 16'(cdiv(ct * ((hd == 0) ? 300 : hd), cn));
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // drive inputs in the current cycle and push the expected result
  task automatic issue_now(input int m, input int ct, input int cn, input int r,
                           input int f, input int hd, input int sf, input int sh);
    mode = 2'(m); clk_ticks = 16'(ct); clk_ns = 16'(cn);
    rise_ns = 16'(r); fall_ns = 16'(f); hold_ns = 16'(hd);
    spk_fast = 8'(sf); spk_high = 8'(sh);
    start = 1'b1;
    sb.push_back(model(m, ct, cn, r, f, hd, sf, sh));
    pushed++;
    @(negedge clk);
    start = 1'b0;
    // R8: scramble inputs right after the sampling edge
    mode = ~mode; clk_ticks = 16'hFFFF; clk_ns = 16'd7; rise_ns = 16'd999;
    fall_ns = 16'd3; hold_ns = 16'd5; spk_fast = 8'd200; spk_high = 8'd200;
  endtask

  task automatic run(input int m, input int ct, input int cn, input int r,
                     input int f, input int hd, input int sf, input int sh);
    @(negedge clk);
    issue_now(m, ct, cn, r, f, hd, sf, sh);
  endtask

  task automatic wait_seen(input int n);
    while (seen < n) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        exp_t e;
        logic [15:0] h0, l0;
        seen++;
        if (sb.size() == 0) begin
          check(1'b0, "R8", "result with no accepted start (act done=1 exp none)");
        end else begin
          e = sb.pop_front();
          check(error === e.err, "R4",
                $sformatf("error act %0b exp %0b", error, e.err));
          check(scl_hcnt === e.h, "R3/R5/R7",
                $sformatf("hcnt act %0d exp %0d", scl_hcnt, e.h));
          check(scl_lcnt === e.l, "R3/R5",
                $sformatf("lcnt act %0d exp %0d", scl_lcnt, e.l));
          check(hold_cnt === e.hd, "R1/R6",
                $sformatf("hold act %0d exp %0d", hold_cnt, e.hd));
        end
        h0 = scl_hcnt; l0 = scl_lcnt;
        @(negedge clk);
        check(done === 1'b0, "R9", $sformatf("done width act %0b exp 0", done));
        check(scl_hcnt === h0 && scl_lcnt === l0, "R9",
              $sformatf("hold act %0d/%0d exp %0d/%0d", scl_hcnt, scl_lcnt, h0, l0));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done === 1'b0 && error === 1'b0 && scl_hcnt === '0 && scl_lcnt === '0
          && hold_cnt === '0, "R10",
          $sformatf("reset outputs act %0b %0b %0d %0d %0d exp 0", done, error,
                    scl_hcnt, scl_lcnt, hold_cnt));

    run(1, 120, 1000, 100, 30, 0, 5, 9);     // R1 R3 R6 R7 fast mode
    wait_seen(1);
    run(0, 400, 3000, 250, 40, 450, 3, 0);   // R2 R5 odd remainder, explicit hold
    wait_seen(2);
    run(2, 120, 1000, 50, 20, 0, 2, 0);      // R2 fast-plus
    wait_seen(3);
    run(3, 120, 1000, 20, 0, 120, 50, 1);    // R7 high speed uses spk_high, hcnt=0 (R4)
    wait_seen(4);
    run(1, 120, 1000, 100, 600, 0, 5, 5);    // R4 negative high count
    wait_seen(5);
    run(3, 400, 3000, 10, 5, 0, 0, 0);       // R2 high speed at other clock

    // R9: start in the same cycle as done
    while (!done) @(negedge clk);
    issue_now(0, 120, 1000, 300, 100, 0, 4, 4);
    wait_seen(7);

    // R8: start while busy is ignored
    run(1, 400, 3000, 120, 10, 200, 1, 1);
    repeat (20) @(negedge clk);
    mode = 2'd3; clk_ticks = 16'd50; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_seen(8);
    repeat (400) @(negedge clk);
    check(seen == pushed && sb.size() == 0, "R8",
          $sformatf("results act %0d exp %0d", seen, pushed));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule